// File: doc/BRIEF.md
# Log-Step Lane Prefix Scan

The block computes an inclusive prefix scan across a row of `LANES` data lanes, one element per lane. A start pulse captures the input vector and an operator code. Over log2(`LANES`) rounds, each lane combines its running value with the running value of the lane a fixed distance to its left. That distance is 1 in the first round and doubles every round, up to `LANES`/2. Lanes that have no partner that far to their left take the operator's identity value instead.

No tree of combiners is built. The only structure is one non-circular neighbour shift per round, with vacated positions filled. When the last round completes, every lane holds the combination of its own element with all elements to its left. The results remain on the output until the next accepted start.

Top module: `lane_scan`

## Requirements
- R1: After a scan, output lane i equals the combination of input lanes 0 through i under the selected operator, computed left to right (for an 8-lane add of 3,5,2,1,4,6,2,7 the result is 3,8,10,11,15,21,23,30).
- R2: The operator code on `op_sel` is 0 add, 1 multiply, 2 bitwise AND, 3 bitwise OR, 4 bitwise XOR, 5 minimum and 6 maximum. Code 7 behaves as add.
- R3: Lanes with no source lane in a round are filled with the operator's identity (0 for add, OR and XOR; 1 for multiply; all ones for AND; the largest representable value for minimum; the smallest for maximum). As a result, output lane 0 always equals input lane 0.
- R4: `done` is high for exactly one cycle, after log2(`LANES`) rising edges counted from the edge that samples `start`. In that cycle the results are valid, and they stay unchanged until the next accepted start.
- R5: A start pulse that arrives while a scan is in progress is ignored. Its operator and data have no effect, and the completion timing of the running scan is unchanged.
- R6: With `SIGNED`=1, minimum and maximum compare lanes as two's-complement values. With `SIGNED`=0, they compare lanes as unsigned values.
- R7: While `rst_n` is low, every output lane reads 0 and `done` is low.
- R8: Results are truncated to `WIDTH` bits, and any overflow wraps silently, including for multiply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan. Sampled only when no scan is running |
| op_sel | input | 3 | Operator code, sampled together with `start` |
| din | input | LANES*WIDTH | Input elements, lane i at bits [i*WIDTH +: WIDTH] |
| dout | output | LANES*WIDTH | Scan results, lane i at bits [i*WIDTH +: WIDTH] |
| done | output | 1 | One-cycle pulse when `dout` holds a new result |

## Verification
The scan results and `done` are due log2(`LANES`) rising edges after the edge that samples `start`. For the default of 8 lanes, that is three edges. The bench drives every input at the falling edge and counts edges from the sampling edge. It requires `done` to be low after each earlier edge and high after the last, and it compares `dout` in that same cycle. One edge later, it checks that `done` has dropped and that `dout` still holds the same values. During the busy cycles, the bench alters `din` and `op_sel` and sometimes raises `start` again, so that any leakage from an ignored request shows up in the result that falls due.

// File: rtl/lane_scan_pkg.sv
package lane_scan_pkg;
   typedef enum logic [2:0] {
      SC_ADD = 3'd0,
      SC_MUL = 3'd1,
      SC_AND = 3'd2,
      SC_OR  = 3'd3,
      SC_XOR = 3'd4,
      SC_MIN = 3'd5,
      SC_MAX = 3'd6,
      SC_RSV = 3'd7
   } scan_op_e;
endpackage

// File: rtl/scan_alu.sv
module scan_alu
   import lane_scan_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit SIGNED = 1'b1
) (
   input  scan_op_e           op,
   input  logic [WIDTH-1:0]   own,
   input  logic [WIDTH-1:0]   nbr,
   output logic [WIDTH-1:0]   y
);
   localparam int PW = 2 * WIDTH;

   logic          lt;
   logic [PW-1:0] prod;

   generate
      if (SIGNED) begin : g_scmp
         assign lt = $signed(own) < $signed(nbr);
      end else begin : g_ucmp
         assign lt = own < nbr;
      end
   endgenerate

   assign prod = {{WIDTH{1'b0}}, own} * {{WIDTH{1'b0}}, nbr};

   always_comb begin
      unique case (op)
         SC_MUL:  y = prod[WIDTH-1:0];
         SC_AND:  y = own & nbr;
         SC_OR:   y = own | nbr;
         SC_XOR:  y = own ^ nbr;
         SC_MIN:  y = lt ? own : nbr;
         SC_MAX:  y = lt ? nbr : own;
         default: y = own + nbr;
      endcase
   end
endmodule

// File: rtl/scan_shift.sv
module scan_shift #(
   parameter int LANES = 8,
   parameter int WIDTH = 8,
   parameter int LOG2N = 3,
   parameter int RW    = 2
) (
   input  logic [LANES-1:0][WIDTH-1:0] vin,
   input  logic [RW-1:0]               rnd,
   input  logic [WIDTH-1:0]            fill,
   output logic [LANES-1:0][WIDTH-1:0] vout
);
   logic [LANES-1:0][LOG2N-1:0][WIDTH-1:0] cand;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         for (genvar k = 0; k < LOG2N; k++) begin : g_dist
            if (i >= (1 << k)) begin : g_src
               assign cand[i][k] = vin[i - (1 << k)];
            end else begin : g_fill
               assign cand[i][k] = fill;
            end
         end
         always_comb begin
            vout[i] = fill;
            for (int k = 0; k < LOG2N; k++) begin
               if (rnd == RW'(k)) vout[i] = cand[i][k];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/scan_seq.sv
module scan_seq #(
   parameter int LOG2N = 3,
   parameter int RW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          accept,
   output logic          step,
   output logic          busy,
   output logic [RW-1:0] cur_rnd,
   output logic          done
);
   localparam logic [RW-1:0] LAST = RW'(LOG2N - 1);

   logic          busy_q, done_q, fin;
   logic [RW-1:0] rnd_q;

   assign accept  = start & ~busy_q;
   assign step    = accept | busy_q;
   assign cur_rnd = busy_q ? rnd_q : '0;
   assign fin     = step & (cur_rnd == LAST);
   assign busy    = busy_q;
   assign done    = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rnd_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= fin;
         if (accept) begin
            busy_q <= ~fin;
            rnd_q  <= RW'(1);
         end else if (busy_q) begin
            if (fin) busy_q <= 1'b0;
            rnd_q <= rnd_q + RW'(1);
         end
      end
   end

   // R5
   busy_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fin) |=> busy_q);
endmodule

// File: rtl/lane_scan.sv
module lane_scan
   import lane_scan_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int WIDTH  = 8,
   parameter bit SIGNED = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [2:0]             op_sel,
   input  logic [LANES*WIDTH-1:0] din,
   output logic [LANES*WIDTH-1:0] dout,
   output logic                   done
);
   localparam int LOG2N = $clog2(LANES);
   localparam int RW    = (LOG2N > 1) ? $clog2(LOG2N) : 1;
   localparam int CW    = $clog2(LOG2N + 1) + 1;
   localparam logic [WIDTH-1:0] MIN_ID = SIGNED ? {1'b0, {(WIDTH-1){1'b1}}} : {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] MAX_ID = SIGNED ? {1'b1, {(WIDTH-1){1'b0}}} : {WIDTH{1'b0}};

   generate
      if (LANES < 2 || (1 << LOG2N) != LANES) begin : g_bad_lanes
         $error("lane_scan: LANES must be a power of two and at least 2");
      end
      if (WIDTH < 2) begin : g_bad_width
         $error("lane_scan: WIDTH must be at least 2");
      end
   endgenerate

   logic                         accept, step, busy;
   logic [RW-1:0]                cur_rnd;
   scan_op_e                     op_q, cur_op;
   logic [WIDTH-1:0]             fill;
   logic [LANES-1:0][WIDTH-1:0]  din_a, part_q, src, shifted, nxt;

   scan_seq #(.LOG2N(LOG2N), .RW(RW)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
      .step(step), .busy(busy), .cur_rnd(cur_rnd), .done(done)
   );

   assign cur_op = busy ? op_q : scan_op_e'(op_sel);
   assign src    = busy ? part_q : din_a;

   always_comb begin
      unique case (cur_op)
         SC_MUL:  fill = WIDTH'(1);
         SC_AND:  fill = '1;
         SC_MIN:  fill = MIN_ID;
         SC_MAX:  fill = MAX_ID;
         default: fill = '0;
      endcase
   end

   scan_shift #(.LANES(LANES), .WIDTH(WIDTH), .LOG2N(LOG2N), .RW(RW)) shift_i (
      .vin(src), .rnd(cur_rnd), .fill(fill), .vout(shifted)
   );

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign din_a[i]                = din[i*WIDTH +: WIDTH];
         assign dout[i*WIDTH +: WIDTH]  = part_q[i];
         scan_alu #(.WIDTH(WIDTH), .SIGNED(SIGNED)) alu_i (
            .op(cur_op), .own(src[i]), .nbr(shifted[i]), .y(nxt[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q <= '0;
         op_q   <= SC_ADD;
      end else begin
         if (step)   part_q <= nxt;
         if (accept) op_q   <= scan_op_e'(op_sel);
      end
   end

   // latency counter used only by the checks below
   logic [CW-1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_q <= '0;
      else if (accept) lat_q <= CW'(1);
      else if (busy)   lat_q <= lat_q + CW'(1);
   end

   // R4
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == CW'(LOG2N)));

   // R3
   lane0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(part_q[0]));

   // R5
   op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(op_q));
endmodule

// File: tb/lane_scan_tb.sv
module lane_scan_tb_top;
   localparam int  N      = 8;
   localparam int  W      = 8;
   localparam int  L      = $clog2(N);
   localparam time CLK_PERIOD = 10ns;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           start;
   logic [2:0]     op_sel;
   logic [N*W-1:0] din;
   logic [N*W-1:0] dout;
   logic           done;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_scan #(.LANES(N), .WIDTH(W), .SIGNED(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
      .din(din), .dout(dout), .done(done)
   );

   function automatic logic [W-1:0] comb(input logic [2:0] op,
                                         input logic [W-1:0] a, input logic [W-1:0] b);
      logic [2*W-1:0] p;
      p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      case (op)
         3'd1:    return p[W-1:0];
         3'd2:    return a & b;
         3'd3:    return a | b;
         3'd4:    return a ^ b;
         3'd5:    return ($signed(a) < $signed(b)) ? a : b;
         3'd6:    return ($signed(a) < $signed(b)) ? b : a;
         default: return a + b;
      endcase
   endfunction

   function automatic logic [N*W-1:0] model(input logic [2:0] op, input logic [N*W-1:0] v);
      logic [N*W-1:0] r;
      logic [W-1:0]   acc;
      acc = v[W-1:0];
      r[W-1:0] = acc;
      for (int i = 1; i < N; i++) begin
         acc = comb(op, acc, v[i*W +: W]);
         r[i*W +: W] = acc;
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [N*W-1:0] act,
                        input logic [N*W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_scan(input logic [2:0] op, input logic [N*W-1:0] vec,
                           input bit poke, input string req);
      logic [N*W-1:0] exp;
      bit             tim_ok;
      exp = model(op, vec);
      @(negedge clk);
      start = 1'b1; op_sel = op; din = vec;
      @(negedge clk);
      start = 1'b0; din = ~vec; op_sel = op ^ 3'd1;
      tim_ok = 1'b1;
      for (int k = 1; k <= L; k++) begin
         if (k > 1) @(negedge clk);
         tim_ok &= (done == (k == L));
         start = (poke && k < L);
         if (poke) din = vec ^ {N{8'h5A}};
      end
      start = 1'b0;
      check(tim_ok, "R4 done timing", {{(N*W-1){1'b0}}, done}, 1);
      check(dout == exp, req, dout, exp);
      check(dout[W-1:0] == vec[W-1:0], "R3 lane0 identity fill",
            {{(N*W-W){1'b0}}, dout[W-1:0]}, {{(N*W-W){1'b0}}, vec[W-1:0]});
      @(negedge clk);
      check(!done && dout == exp, "R4 single pulse and hold", dout, exp);
   endtask

   function automatic logic [N*W-1:0] pack(input int e0, e1, e2, e3, e4, e5, e6, e7);
      return {W'(e7), W'(e6), W'(e5), W'(e4), W'(e3), W'(e2), W'(e1), W'(e0)};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd2024);
      rst_n = 1'b0; start = 1'b0; op_sel = 3'd0; din = '0;
      repeat (3) @(negedge clk);
      // R7
      check(dout == '0 && !done, "R7 reset state", dout, '0);
      rst_n = 1'b1;

      // R1 worked example
      run_scan(3'd0, pack(3,5,2,1,4,6,2,7), 1'b0, "R1 add example");
      check(dout == pack(3,8,10,11,15,21,23,30), "R1 add example literal", dout,
            pack(3,8,10,11,15,21,23,30));
      // R8 multiply wraps
      run_scan(3'd1, pack(3,3,3,3,3,3,3,3), 1'b0, "R8 multiply wrap");
      run_scan(3'd0, pack(200,100,250,7,255,1,128,90), 1'b0, "R8 add wrap");
      // R2 each operator
      run_scan(3'd2, pack(8'hFF,8'hF7,8'h7F,8'hFE,8'hEF,8'hFF,8'hBF,8'hFD), 1'b0, "R2 and");
      run_scan(3'd3, pack(1,2,4,8,16,32,64,128), 1'b0, "R2 or");
      run_scan(3'd4, pack(8'h81,8'h42,8'h24,8'h18,8'h81,8'h42,8'h24,8'h18), 1'b0, "R2 xor");
      run_scan(3'd7, pack(1,2,3,4,5,6,7,8), 1'b0, "R2 code 7 as add");
      // R6 signed compare
      run_scan(3'd5, pack(5,-3,7,-128,4,127,-1,0), 1'b0, "R6 signed min");
      run_scan(3'd6, pack(-5,-3,-7,-128,4,127,-1,0), 1'b0, "R6 signed max");
      run_scan(3'd6, pack(-128,-128,-100,-128,-1,-2,-3,-4), 1'b0, "R6 max all negative");
      // R5 start during busy ignored
      run_scan(3'd0, pack(1,1,1,1,1,1,1,1), 1'b1, "R5 busy start ignored");
      run_scan(3'd5, pack(9,8,7,6,5,4,3,2), 1'b1, "R5 busy start ignored min");

      for (int t = 0; t < 30; t++) begin
         logic [N*W-1:0] v;
         for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
         run_scan(3'($urandom % 8), v, 1'($urandom % 2), "R1 random scan");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule